// File: doc/BRIEF.md
# Flash Command Interface Sequencer

This block sits between a host bus and a flash array's program/erase engine. The host writes 8-bit commands on the low byte of the data bus, and each write is qualified by a single-cycle strobe. The block decodes these commands and runs the two-step erase and program flows. When a flow is accepted, it sends a one-cycle start request to the engine, together with the latched target address and data. The engine reports back through a done pulse, and that pulse carries a fail flag.

The block also keeps the 8-bit status byte and chooses which source the read path shows: the array, the status byte or the identification registers. It checks the supply flag and the protection flag at the cycle that would start an operation. It keeps checking the supply flag for as long as the engine is busy, and it takes an abort request from outside. Any refused, aborted or failed operation leaves a sticky error bit. A clear command removes those bits.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: While rst_ni is low and after it rises, the read mode is array (0), the status byte is 80h and neither start output is high.
- R2: Writing 20h and then D0h starts an erase. ers_start_o is high for exactly one cycle, in the cycle after the D0h write, and op_addr_o holds the address given with the D0h write.
- R3: Writing 10h or 40h and then one more write starts a program. prg_start_o is high for exactly one cycle after that second write, and op_addr_o and op_data_o hold its address and full data word.
- R4: rd_mode_o encodes array as 0, status as 1 and identification as 2. Outside a busy period, FFh selects array, 70h selects status and 90h selects identification.
- R5: The second cycle of an erase or program flow sets the read mode to status. This holds whether the operation starts or is refused.
- R6: While the engine is busy, rd_mode_o is 1 and status bit 7 (ready) is 0, whatever mode was selected before.
- R7: The status byte is laid out as bit 7 ready, bit 6 erase-suspended (always 0 here), bit 5 erase error, bit 4 program error and bit 3 supply error. Bits 2 to 0 are 0.
- R8: A done pulse from the engine ends the busy period and sets ready. If the fail flag comes with it, the error bit of the running operation is also set.
- R9: If the write that follows 20h is anything other than D0h, bits 5 and 4 are both set and no start is issued.
- R10: Two supply faults end in the same way. If vpp_ok_i is low at the starting cycle, no start is issued. If it drops while busy, the operation ends. In both cases bit 3 and the error bit of that operation are set, and ready is 1.
- R11: If prot_ok_i is low at the starting cycle, no start is issued, the operation's error bit is set and ready stays 1.
- R12: abort_i during a busy period ends it, sets the running operation's error bit and returns ready.
- R13: 50h clears bits 5, 4 and 3. Apart from reset, nothing else clears them.
- R14: While busy, every command write other than 70h is ignored. It changes neither the read mode, nor the error bits, nor the flow state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_i | input | 1 | Command/data write strobe, one cycle per write |
| data_i | input | DW | Write data; commands use bits 7:0 |
| addr_i | input | AW | Write address |
| prot_ok_i | input | 1 | Protection allows an operation at addr_i |
| vpp_ok_i | input | 1 | Programming supply present |
| abort_i | input | 1 | Abort the running operation |
| eng_done_i | input | 1 | Engine finished the operation |
| eng_fail_i | input | 1 | Engine operation failed (valid with eng_done_i) |
| rd_mode_o | output | 2 | Read source select: 0 array, 1 status, 2 identification |
| status_o | output | 8 | Status byte |
| prg_start_o | output | 1 | Program start request pulse |
| ers_start_o | output | 1 | Erase start request pulse |
| op_addr_o | output | AW | Latched target address |
| op_data_o | output | DW | Latched program data |

## Verification
Some properties are checked on every cycle by the assertions. A start pulse must follow an accepted confirm or data write, with the supply and protection flags present. The latched data must match that write. The two start requests are mutually exclusive. A clear status ready must force the status read mode. A busy period that receives neither done nor abort, and keeps its supply, must stay busy even when commands are written. Error bits may fall only after a clear command.

Other behaviour shows only in the bench's scenarios, which compare against a reference model on every clock. These include the exact status codes after a failed, refused or aborted operation. They also include a mode request that was ignored during busy, the mode that remains after done, and the handling of a wrong confirm byte.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  typedef enum logic [1:0] {
    RD_ARRAY  = 2'd0,
    RD_STATUS = 2'd1,
    RD_IDENT  = 2'd2
  } rd_mode_e;

  localparam logic [7:0] CMD_READ_ARRAY    = 8'hFF;
  localparam logic [7:0] CMD_READ_STATUS   = 8'h70;
  localparam logic [7:0] CMD_READ_ID       = 8'h90;
  localparam logic [7:0] CMD_CLR_STATUS    = 8'h50;
  localparam logic [7:0] CMD_ERASE_SETUP   = 8'h20;
  localparam logic [7:0] CMD_ERASE_CONFIRM = 8'hD0;
  localparam logic [7:0] CMD_PROG_SETUP    = 8'h10;
  localparam logic [7:0] CMD_PROG_SETUP2   = 8'h40;

  localparam int SB_READY   = 7;
  localparam int SB_SUSP    = 6;
  localparam int SB_ERS_ERR = 5;
  localparam int SB_PRG_ERR = 4;
  localparam int SB_VPP_ERR = 3;

  typedef struct packed {
    logic clr;
    logic ers;
    logic prg;
    logic vpp;
  } err_ev_t;

  typedef struct packed {
    logic     req;
    rd_mode_e mode;
  } mode_req_t;

endpackage

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import flash_cmd_pkg::*;
#(
  parameter int AW = 18,
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [DW-1:0] data_i,
  input  logic [AW-1:0] addr_i,
  input  logic          prot_ok_i,
  input  logic          vpp_ok_i,
  input  logic          abort_i,
  input  logic          eng_done_i,
  input  logic          eng_fail_i,
  output logic          busy_o,
  output err_ev_t       ev_o,
  output mode_req_t     mode_req_o,
  output logic          prg_start_o,
  output logic          ers_start_o,
  output logic [AW-1:0] op_addr_o,
  output logic [DW-1:0] op_data_o
);

  typedef enum logic [1:0] {S_IDLE, S_ERS_SETUP, S_PRG_SETUP, S_BUSY} seq_state_e;

  seq_state_e    state_q, state_d;
  logic          op_ers_q, op_ers_d;
  logic          start_prg_d, start_ers_d;
  logic          prg_start_q, ers_start_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;
  logic [7:0]    cmd;

  assign cmd = data_i[7:0];

  always_comb begin
    state_d         = state_q;
    op_ers_d        = op_ers_q;
    start_prg_d     = 1'b0;
    start_ers_d     = 1'b0;
    ev_o            = '{clr: 1'b0, ers: 1'b0, prg: 1'b0, vpp: 1'b0};
    mode_req_o.req  = 1'b0;
    mode_req_o.mode = RD_ARRAY;
    unique case (state_q)
      S_IDLE: begin
        if (wr_i) begin
          unique case (cmd)
            CMD_READ_ARRAY:  begin mode_req_o.req = 1'b1; mode_req_o.mode = RD_ARRAY;  end
            CMD_READ_STATUS: begin mode_req_o.req = 1'b1; mode_req_o.mode = RD_STATUS; end
            CMD_READ_ID:     begin mode_req_o.req = 1'b1; mode_req_o.mode = RD_IDENT;  end
            CMD_CLR_STATUS:  ev_o.clr = 1'b1;
            CMD_ERASE_SETUP: state_d = S_ERS_SETUP;
            CMD_PROG_SETUP, CMD_PROG_SETUP2: state_d = S_PRG_SETUP;
            default: ;
          endcase
        end
      end
      S_ERS_SETUP: begin
        if (wr_i) begin
          mode_req_o.req  = 1'b1;
          mode_req_o.mode = RD_STATUS;
          state_d         = S_IDLE;
          if (cmd != CMD_ERASE_CONFIRM) begin
            ev_o.ers = 1'b1;
            ev_o.prg = 1'b1;
          end else if (!vpp_ok_i) begin
            ev_o.vpp = 1'b1;
            ev_o.ers = 1'b1;
          end else if (!prot_ok_i) begin
            ev_o.ers = 1'b1;
          end else begin
            start_ers_d = 1'b1;
            op_ers_d    = 1'b1;
            state_d     = S_BUSY;
          end
        end
      end
      S_PRG_SETUP: begin
        if (wr_i) begin
          mode_req_o.req  = 1'b1;
          mode_req_o.mode = RD_STATUS;
          state_d         = S_IDLE;
          if (!vpp_ok_i) begin
            ev_o.vpp = 1'b1;
            ev_o.prg = 1'b1;
          end else if (!prot_ok_i) begin
            ev_o.prg = 1'b1;
          end else begin
            start_prg_d = 1'b1;
            op_ers_d    = 1'b0;
            state_d     = S_BUSY;
          end
        end
      end
      S_BUSY: begin
        if (wr_i && cmd == CMD_READ_STATUS) begin
          mode_req_o.req  = 1'b1;
          mode_req_o.mode = RD_STATUS;
        end
        if (abort_i) begin
          ev_o.ers = op_ers_q;
          ev_o.prg = !op_ers_q;
          state_d  = S_IDLE;
        end else if (!vpp_ok_i) begin
          ev_o.vpp = 1'b1;
          ev_o.ers = op_ers_q;
          ev_o.prg = !op_ers_q;
          state_d  = S_IDLE;
        end else if (eng_done_i) begin
          ev_o.ers = eng_fail_i && op_ers_q;
          ev_o.prg = eng_fail_i && !op_ers_q;
          state_d  = S_IDLE;
        end
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= S_IDLE;
      op_ers_q    <= 1'b0;
      prg_start_q <= 1'b0;
      ers_start_q <= 1'b0;
      addr_q      <= '0;
      data_q      <= '0;
    end else begin
      state_q     <= state_d;
      op_ers_q    <= op_ers_d;
      prg_start_q <= start_prg_d;
      ers_start_q <= start_ers_d;
      if (start_prg_d || start_ers_d) addr_q <= addr_i;
      if (start_prg_d) data_q <= data_i;
    end
  end

  assign busy_o      = (state_q == S_BUSY);
  assign prg_start_o = prg_start_q;
  assign ers_start_o = ers_start_q;
  assign op_addr_o   = addr_q;
  assign op_data_o   = data_q;

  AST_ONE_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(prg_start_o && ers_start_o)); // R2
  AST_ERS_AFTER_CONFIRM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ers_start_o |-> $past(wr_i && data_i[7:0] == CMD_ERASE_CONFIRM) && op_addr_o == $past(addr_i)); // R2
  AST_PRG_LATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prg_start_o |-> $past(wr_i) && op_data_o == $past(data_i) && op_addr_o == $past(addr_i)); // R3
  AST_START_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prg_start_o || ers_start_o) |-> busy_o); // R6
  AST_START_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prg_start_o || ers_start_o) |-> $past(vpp_ok_i && prot_ok_i)); // R10
  AST_BUSY_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && wr_i && !eng_done_i && !abort_i && vpp_ok_i) |=> busy_o); // R14

endmodule

// File: rtl/flash_cmd_status.sv
module flash_cmd_status
  import flash_cmd_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  err_ev_t ev_i,
  input  logic    busy_i,
  output logic [7:0] status_o
);

  logic ers_err_q, prg_err_q, vpp_err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ers_err_q <= 1'b0;
      prg_err_q <= 1'b0;
      vpp_err_q <= 1'b0;
    end else if (ev_i.clr) begin
      ers_err_q <= 1'b0;
      prg_err_q <= 1'b0;
      vpp_err_q <= 1'b0;
    end else begin
      ers_err_q <= ers_err_q | ev_i.ers;
      prg_err_q <= prg_err_q | ev_i.prg;
      vpp_err_q <= vpp_err_q | ev_i.vpp;
    end
  end

  always_comb begin
    status_o             = '0;
    status_o[SB_READY]   = !busy_i;
    status_o[SB_SUSP]    = 1'b0;
    status_o[SB_ERS_ERR] = ers_err_q;
    status_o[SB_PRG_ERR] = prg_err_q;
    status_o[SB_VPP_ERR] = vpp_err_q;
  end

  AST_ERS_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ers_err_q) |-> $past(ev_i.clr)); // R13
  AST_PRG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(prg_err_q) |-> $past(ev_i.clr)); // R13
  AST_VPP_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(vpp_err_q) |-> $past(ev_i.clr)); // R13

endmodule

// File: rtl/flash_cmd_mode.sv
module flash_cmd_mode
  import flash_cmd_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  mode_req_t req_i,
  input  logic      busy_i,
  output rd_mode_e  mode_o
);

  rd_mode_e mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        mode_q <= RD_ARRAY;
    else if (req_i.req) mode_q <= req_i.mode;
  end

  // busy overrides the stored selection without losing it
  assign mode_o = busy_i ? RD_STATUS : mode_q;

endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import flash_cmd_pkg::*;
#(
  parameter int AW = 18,
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [DW-1:0] data_i,
  input  logic [AW-1:0] addr_i,
  input  logic          prot_ok_i,
  input  logic          vpp_ok_i,
  input  logic          abort_i,
  input  logic          eng_done_i,
  input  logic          eng_fail_i,
  output logic [1:0]    rd_mode_o,
  output logic [7:0]    status_o,
  output logic          prg_start_o,
  output logic          ers_start_o,
  output logic [AW-1:0] op_addr_o,
  output logic [DW-1:0] op_data_o
);

  logic      busy;
  err_ev_t   ev;
  mode_req_t mode_req;
  rd_mode_e  mode;

  flash_cmd_seq #(.AW(AW), .DW(DW)) u_seq (
    .clk_i, .rst_ni, .wr_i, .data_i, .addr_i, .prot_ok_i, .vpp_ok_i,
    .abort_i, .eng_done_i, .eng_fail_i,
    .busy_o      (busy),
    .ev_o        (ev),
    .mode_req_o  (mode_req),
    .prg_start_o (prg_start_o),
    .ers_start_o (ers_start_o),
    .op_addr_o   (op_addr_o),
    .op_data_o   (op_data_o)
  );

  flash_cmd_status u_status (
    .clk_i, .rst_ni,
    .ev_i     (ev),
    .busy_i   (busy),
    .status_o (status_o)
  );

  flash_cmd_mode u_mode (
    .clk_i, .rst_ni,
    .req_i  (mode_req),
    .busy_i (busy),
    .mode_o (mode)
  );

  assign rd_mode_o = mode;

  AST_NOT_READY_STATUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !status_o[SB_READY] |-> rd_mode_o == RD_STATUS); // R6

endmodule

// File: tb/flash_cmd_ctrl_test.sv
module flash_cmd_ctrl_test;
  localparam int AW = 18;
  localparam int DW = 16;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic wr_i = 1'b0;
  logic [DW-1:0] data_i = '0;
  logic [AW-1:0] addr_i = '0;
  logic prot_ok_i = 1'b1, vpp_ok_i = 1'b1, abort_i = 1'b0;
  logic eng_done_i = 1'b0, eng_fail_i = 1'b0;
  logic [1:0] rd_mode_o;
  logic [7:0] status_o;
  logic prg_start_o, ers_start_o;
  logic [AW-1:0] op_addr_o;
  logic [DW-1:0] op_data_o;

  flash_cmd_ctrl #(.AW(AW), .DW(DW)) uut (.*);

  always #4 clk_i = ~clk_i;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done_flag = 0;

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // reference model
  int m_st = 0; // 0 idle, 1 erase setup, 2 program setup, 3 busy
  int m_mode = 0;
  bit m_ers_op = 0, m_e = 0, m_p = 0, m_v = 0, m_ps = 0, m_es = 0;
  logic [AW-1:0] m_addr = '0;
  logic [DW-1:0] m_data = '0;

  function automatic void op_err();
    if (m_ers_op) m_e = 1; else m_p = 1;
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_st = 0; m_mode = 0; m_e = 0; m_p = 0; m_v = 0; m_ps = 0; m_es = 0;
      m_addr = '0; m_data = '0; m_ers_op = 0;
    end else begin
      m_ps = 0; m_es = 0;
      case (m_st)
        0: if (wr_i) begin
          case (data_i[7:0])
            8'hFF: m_mode = 0;
            8'h70: m_mode = 1;
            8'h90: m_mode = 2;
            8'h50: begin m_e = 0; m_p = 0; m_v = 0; end
            8'h20: m_st = 1;
            8'h10, 8'h40: m_st = 2;
            default: ;
          endcase
        end
        1, 2: if (wr_i) begin
          m_mode = 1;
          m_ers_op = (m_st == 1);
          m_st = 0;
          if (m_ers_op && data_i[7:0] != 8'hD0) begin m_e = 1; m_p = 1; end
          else if (!vpp_ok_i) begin m_v = 1; op_err(); end
          else if (!prot_ok_i) op_err();
          else begin
            m_st = 3; m_addr = addr_i;
            if (m_ers_op) m_es = 1; else begin m_ps = 1; m_data = data_i; end
          end
        end
        default: begin
          if (abort_i) begin op_err(); m_st = 0; end
          else if (!vpp_ok_i) begin m_v = 1; op_err(); m_st = 0; end
          else if (eng_done_i) begin if (eng_fail_i) op_err(); m_st = 0; end
        end
      endcase
    end
  end

  function automatic logic [7:0] m_status();
    return {m_st != 3, 1'b0, m_e, m_p, m_v, 3'b000};
  endfunction

  always @(negedge clk_i) begin
    if (rst_ni && !done_flag) begin
      chk(rd_mode_o, (m_st == 3) ? 1 : m_mode, "R4 mode vs model");
      chk(status_o, m_status(), "R7 status vs model");
      chk(prg_start_o, m_ps, "R3 prg_start vs model");
      chk(ers_start_o, m_es, "R2 ers_start vs model");
      if (m_ps || m_es) chk(op_addr_o, m_addr, "R2 op_addr vs model");
      if (m_ps) chk(op_data_o, m_data, "R3 op_data vs model");
    end
  end

  always @(posedge clk_i) begin
    cyc++;
    if (cyc == 50000 && !done_flag) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic wr(input logic [7:0] c, input logic [DW-1:0] d = '0, input logic [AW-1:0] a = '0);
    @(negedge clk_i);
    wr_i = 1'b1; data_i = (d != '0) ? d : {{(DW-8){1'b0}}, c}; addr_i = a;
    @(negedge clk_i);
    wr_i = 1'b0;
  endtask

  task automatic eng(input logic fail);
    @(negedge clk_i); eng_done_i = 1'b1; eng_fail_i = fail;
    @(negedge clk_i); eng_done_i = 1'b0; eng_fail_i = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  initial begin
    idle(2);
    chk(rd_mode_o, 0, "R1 mode in reset");
    chk(status_o, 8'h80, "R1 status in reset");
    rst_ni = 1'b1;
    idle(2);
    chk(status_o, 8'h80, "R1 status after reset");
    chk(prg_start_o | ers_start_o, 0, "R1 no start");

    wr(8'h90); chk(rd_mode_o, 2, "R4 ident");
    wr(8'h70); chk(rd_mode_o, 1, "R4 status");
    wr(8'hFF); chk(rd_mode_o, 0, "R4 array");

    // program via 40h
    wr(8'h40);
    wr(8'h00, 16'hA5C3, 18'h00123);
    chk(prg_start_o, 1, "R3 start pulse");
    chk(op_data_o, 16'hA5C3, "R3 data");
    chk(op_addr_o, 18'h00123, "R3 addr");
    chk(status_o, 8'h00, "R6 busy status");
    chk(rd_mode_o, 1, "R5 status mode after data");
    idle(1); chk(prg_start_o, 0, "R3 single pulse");
    wr(8'hFF); chk(rd_mode_o, 1, "R6 busy forces status");
    wr(8'h90); idle(2);
    eng(1'b0);
    chk(status_o, 8'h80, "R8 done ready");
    chk(rd_mode_o, 1, "R14 mode writes ignored while busy");

    // erase with engine failure
    wr(8'hFF);
    wr(8'h20);
    wr(8'hD0, '0, 18'h3E000);
    chk(ers_start_o, 1, "R2 erase start");
    chk(op_addr_o, 18'h3E000, "R2 block addr");
    idle(3);
    eng(1'b1);
    chk(status_o, 8'hA0, "R8 erase fail bit");

    // clear during busy ignored
    wr(8'h10); wr(8'h00, 16'h0F0F, 18'h00010);
    wr(8'h50);
    eng(1'b0);
    chk(status_o, 8'hA0, "R14 clear ignored while busy");
    wr(8'h50); chk(status_o, 8'h80, "R13 clear");
    chk(rd_mode_o, 1, "R13 clear keeps mode");

    // bad confirm
    wr(8'hFF);
    wr(8'h20); wr(8'h33);
    chk(ers_start_o, 0, "R9 no start");
    chk(status_o, 8'hB0, "R9 both errors");
    chk(rd_mode_o, 1, "R5 status after refused");
    idle(2); chk(status_o, 8'hB0, "R13 sticky");

    // supply absent at data cycle
    wr(8'h50);
    vpp_ok_i = 1'b0;
    wr(8'h10); wr(8'h00, 16'h1234, 18'h00400);
    chk(prg_start_o, 0, "R10 no start without supply");
    chk(status_o, 8'h98, "R10 supply+program error");
    vpp_ok_i = 1'b1;

    // protection refused
    wr(8'h50);
    prot_ok_i = 1'b0;
    wr(8'h20); wr(8'hD0, '0, 18'h3F000);
    chk(ers_start_o, 0, "R11 no start when protected");
    chk(status_o, 8'hA0, "R11 erase error ready");
    prot_ok_i = 1'b1;

    // abort
    wr(8'h50);
    wr(8'h20); wr(8'hD0, '0, 18'h10000);
    idle(2);
    @(negedge clk_i); abort_i = 1'b1;
    @(negedge clk_i); abort_i = 1'b0;
    chk(status_o, 8'hA0, "R12 abort sets error");

    // supply drop while busy
    wr(8'h50);
    wr(8'h40); wr(8'h00, 16'hBEEF, 18'h00777);
    idle(2);
    @(negedge clk_i); vpp_ok_i = 1'b0;
    @(negedge clk_i); vpp_ok_i = 1'b1;
    chk(status_o, 8'h98, "R10 supply drop while busy");

    // reset clears
    @(negedge clk_i); rst_ni = 1'b0;
    @(negedge clk_i);
    chk(status_o, 8'h80, "R1 reset clears errors");
    chk(rd_mode_o, 0, "R1 reset array mode");
    rst_ni = 1'b1;
    idle(3);

    done_flag = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule